// File: doc/BRIEF.md
# Transmit Descriptor Ring Walker

This block walks a ring of transmit buffer descriptors in memory for an Ethernet-style MAC. Each descriptor takes 16 bytes. Its first word holds the byte address of a data buffer and its second word holds control and status. The block fetches each descriptor over a simple request/acknowledge memory port and hands the buffer address, length, CRC-append flag and last-buffer flag to a frame engine. When the engine reports the outcome of a frame, the block writes status back into the control word of that frame's first descriptor.

Software programs a ring base address and raises the enable. A start pulse sets the transmit-go flag and the block then fetches descriptors until one of these stops it: a descriptor it does not own, a transmit error, a halt request or a disable. A halt request waits for the frame in flight to finish. An external pause indication holds off the next frame while pause handling is enabled. A collision makes the block fetch the frame again from its first descriptor.

Top module: `tx_bdq`

## Requirements
- R1: Each buffer handed to the frame engine carries word 0 as its address. From word 1 it carries the length in bits 13:0, the last-buffer flag in bit 15 and the CRC-append flag in bit 16. Buffers are handed over in ring order.
- R2: When a fetched control word has bit 31 (owned by software) set, no buffer is issued, transmit-go clears and the queue pointer returns to the first descriptor of the frame being assembled.
- R3: When a frame completes without collision, the block makes one write to the control word (pointer + 4) of the frame's first descriptor. Bit 31 is 1, bit 30 is that descriptor's wrap flag, bits 29:20 are the engine status (bit 23 marks a captured timestamp) and bits 19:0 are zero. Other descriptors of the frame are not written.
- R4: A control word with bit 30 set sends the next fetch to the base address. Otherwise the pointer advances by 16.
- R5: A base-address write takes effect only while the block is disabled, or while transmit-go is clear and no frame is in progress. At all other times it is ignored.
- R6: While disabled, the queue pointer equals the base address one cycle later. A halt leaves the pointer at the descriptor after the last completed frame.
- R7: A start pulse sets transmit-go. Another start pulse while active changes nothing.
- R8: Transmit-go clears on disable, on an owned-by-software descriptor, on a taken halt and on an engine error.
- R9: A halt request takes effect only after the current frame's status write has finished, and no further frame is fetched.
- R10: While pause handling is enabled and pause is active, no new frame's descriptor is fetched.
- R11: A collision result makes the block fetch again from the frame's first descriptor, with no status write for that attempt.
- R12: An error result writes the status (per R3), clears transmit-go and leaves the pointer at the failed frame's first descriptor.
- R13: A descriptor fetch reads word 0 at the pointer, then word 1 at pointer + 4. Each read waits for its acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tx_en_i | input | 1 | Transmit enable level |
| start_i | input | 1 | Start pulse, sets transmit-go |
| halt_i | input | 1 | Halt request pulse |
| base_we_i | input | 1 | Base-address write strobe |
| base_i | input | AW | Base-address write data (16-byte aligned) |
| pause_en_i | input | 1 | Pause handling enable |
| pause_i | input | 1 | Pause indication |
| go_o | output | 1 | Transmit-go status |
| qptr_o | output | AW | Current queue pointer |
| mem_req_o | output | 1 | Memory request |
| mem_we_o | output | 1 | Memory write (1) or read (0) |
| mem_addr_o | output | AW | Memory byte address |
| mem_wdata_o | output | 32 | Status write data |
| mem_ack_i | input | 1 | Memory acknowledge |
| mem_rdata_i | input | 32 | Memory read data |
| buf_valid_o | output | 1 | Buffer offered to frame engine |
| buf_ready_i | input | 1 | Frame engine accepts buffer |
| buf_addr_o | output | 32 | Buffer byte address |
| buf_len_o | output | 14 | Buffer length |
| buf_crc_o | output | 1 | Append CRC |
| buf_last_o | output | 1 | Last buffer of frame |
| res_valid_i | input | 1 | Frame result strobe |
| res_coll_i | input | 1 | Result is a collision |
| res_err_i | input | 1 | Result is an error |
| res_stat_i | input | 10 | Status bits for the write-back |

## Verification
The bench sends a wrapped two-frame ring that ends on a descriptor already returned to software. A design that writes status into the last descriptor, or that keeps fetching past the wrap, shows stray memory contents or extra buffers. A halt and a base write are issued while a frame is held open. A design that halts at once, or that accepts the base write, stops before the write-back or lands on the wrong pointer after a disable. A collision on a two-buffer frame must replay both buffers with a single write-back, and an error must park the pointer on the failed frame. Pause must hold off every memory read.

// File: rtl/tx_bdq_pkg.sv
package tx_bdq_pkg;
  localparam int USED_BIT    = 31;
  localparam int WRAP_BIT    = 30;
  localparam int CRC_BIT     = 16;
  localparam int LAST_BIT    = 15;
  localparam int LEN_W       = 14;
  localparam int STAT_W      = 10;
  localparam int STAT_LSB    = 20;
  localparam int DESC_BYTES  = 16;
  localparam int CTRL_OFFSET = 4;

  typedef enum logic [2:0] {
    S_IDLE, S_RD0, S_RD1, S_ISSUE, S_WAIT, S_WB
  } walk_state_e;
endpackage

// File: rtl/tx_bdq_ctrl.sv
module tx_bdq_ctrl #(
  parameter int AW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic          start_i,
  input  logic          halt_i,
  input  logic          base_we_i,
  input  logic [AW-1:0] base_i,
  input  logic          idle_i,
  input  logic          clr_go_i,
  input  logic          halt_ack_i,
  output logic          go_o,
  output logic          halt_pend_o,
  output logic [AW-1:0] base_o
);
  logic          go_q, pend_q;
  logic [AW-1:0] base_q;
  logic          base_open;

  assign base_open = !en_i || (!go_q && idle_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      go_q   <= 1'b0;
      pend_q <= 1'b0;
      base_q <= '0;
    end else begin
      if (base_we_i && base_open) base_q <= base_i;
      if (!en_i) begin
        go_q   <= 1'b0;
        pend_q <= 1'b0;
      end else begin
        if (clr_go_i || halt_ack_i) go_q <= 1'b0;
        else if (start_i)           go_q <= 1'b1;
        if (clr_go_i || halt_ack_i) pend_q <= 1'b0;
        else if (halt_i)            pend_q <= 1'b1;
        else if (start_i)           pend_q <= 1'b0;
      end
    end
  end

  assign go_o        = go_q;
  assign halt_pend_o = pend_q;
  assign base_o      = base_q;

  p_base_locked_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && go_q && base_we_i) |=> $stable(base_q));
  p_go_needs_start_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(go_q) |-> $past(start_i));
  p_disable_clears_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> !go_q);
endmodule

// File: rtl/tx_bdq_walker.sv
module tx_bdq_walker
  import tx_bdq_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              go_i,
  input  logic              halt_pend_i,
  input  logic              pause_en_i,
  input  logic              pause_i,
  input  logic [AW-1:0]     base_i,
  output logic [AW-1:0]     qptr_o,
  output logic              idle_o,
  output logic              clr_go_o,
  output logic              halt_ack_o,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [AW-1:0]     mem_addr_o,
  output logic [31:0]       mem_wdata_o,
  input  logic              mem_ack_i,
  input  logic [31:0]       mem_rdata_i,
  output logic              buf_valid_o,
  input  logic              buf_ready_i,
  output logic [31:0]       buf_addr_o,
  output logic [LEN_W-1:0]  buf_len_o,
  output logic              buf_crc_o,
  output logic              buf_last_o,
  input  logic              res_valid_i,
  input  logic              res_coll_i,
  input  logic              res_err_i,
  input  logic [STAT_W-1:0] res_stat_i
);
  localparam logic [AW-1:0] STRIDE = AW'(DESC_BYTES);
  localparam logic [AW-1:0] CTRL_O = AW'(CTRL_OFFSET);

  walk_state_e        st_q;
  logic [AW-1:0]      ptr_q, first_q;
  logic [31:0]        addr_q, ctrl_q;
  logic               first_wrap_q, is_first_q;
  logic [STAT_W-1:0]  stat_q;
  logic               suspend, used_hit, err_hit;

  assign suspend  = pause_en_i && pause_i;
  assign used_hit = (st_q == S_RD1) && mem_ack_i && mem_rdata_i[USED_BIT];
  assign err_hit  = (st_q == S_WAIT) && res_valid_i && !res_coll_i && res_err_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q         <= S_IDLE;
      ptr_q        <= '0;
      first_q      <= '0;
      addr_q       <= '0;
      ctrl_q       <= '0;
      first_wrap_q <= 1'b0;
      is_first_q   <= 1'b0;
      stat_q       <= '0;
    end else if (!en_i) begin
      st_q  <= S_IDLE;
      ptr_q <= base_i;
    end else begin
      unique case (st_q)
        S_IDLE: if (!halt_pend_i && go_i && !suspend) begin
          first_q    <= ptr_q;
          is_first_q <= 1'b1;
          st_q       <= S_RD0;
        end
        S_RD0: if (mem_ack_i) begin
          addr_q <= mem_rdata_i;
          st_q   <= S_RD1;
        end
        S_RD1: if (mem_ack_i) begin
          if (mem_rdata_i[USED_BIT]) begin
            ptr_q <= first_q;
            st_q  <= S_IDLE;
          end else begin
            ctrl_q <= mem_rdata_i;
            if (is_first_q) first_wrap_q <= mem_rdata_i[WRAP_BIT];
            is_first_q <= 1'b0;
            ptr_q <= mem_rdata_i[WRAP_BIT] ? base_i : ptr_q + STRIDE;
            st_q  <= S_ISSUE;
          end
        end
        S_ISSUE: if (buf_ready_i) st_q <= ctrl_q[LAST_BIT] ? S_WAIT : S_RD0;
        S_WAIT: if (res_valid_i) begin
          if (res_coll_i) begin
            ptr_q      <= first_q;
            is_first_q <= 1'b1;
            st_q       <= S_RD0;
          end else begin
            stat_q <= res_stat_i;
            if (res_err_i) ptr_q <= first_q;
            st_q <= S_WB;
          end
        end
        S_WB: if (mem_ack_i) st_q <= S_IDLE;
        default: st_q <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    unique case (st_q)
      S_RD0:   mem_addr_o = ptr_q;
      S_RD1:   mem_addr_o = ptr_q + CTRL_O;
      default: mem_addr_o = first_q + CTRL_O;
    endcase
  end

  assign mem_req_o   = en_i && (st_q == S_RD0 || st_q == S_RD1 || st_q == S_WB);
  assign mem_we_o    = (st_q == S_WB);
  assign mem_wdata_o = {1'b1, first_wrap_q, stat_q, {STAT_LSB{1'b0}}};
  assign buf_valid_o = en_i && (st_q == S_ISSUE);
  assign buf_addr_o  = addr_q;
  assign buf_len_o   = ctrl_q[LEN_W-1:0];
  assign buf_crc_o   = ctrl_q[CRC_BIT];
  assign buf_last_o  = ctrl_q[LAST_BIT];
  assign halt_ack_o  = en_i && (st_q == S_IDLE) && halt_pend_i;
  assign clr_go_o    = en_i && (used_hit || err_hit);
  assign idle_o      = (st_q == S_IDLE);
  assign qptr_o      = ptr_q;

  p_disabled_ptr_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (qptr_o == $past(base_i)));
  p_used_no_issue_r2: assert property (@(posedge clk_i) disable iff (!rst_ni || !en_i)
    (used_hit && en_i) |=> !buf_valid_o);
  p_coll_refetch_r11: assert property (@(posedge clk_i) disable iff (!rst_ni || !en_i)
    (st_q == S_WAIT && res_valid_i && res_coll_i)
      |=> (mem_req_o && !mem_we_o && mem_addr_o == $past(first_q)));
  p_pause_holds_r10: assert property (@(posedge clk_i) disable iff (!rst_ni || !en_i)
    (st_q == S_IDLE && suspend) |=> !mem_req_o);
  p_read_order_r13: assert property (@(posedge clk_i) disable iff (!rst_ni || !en_i)
    (st_q == S_RD0 && mem_ack_i) |=> (mem_addr_o == $past(mem_addr_o) + CTRL_O));
endmodule

// File: rtl/tx_bdq.sv
module tx_bdq
  import tx_bdq_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tx_en_i,
  input  logic              start_i,
  input  logic              halt_i,
  input  logic              base_we_i,
  input  logic [AW-1:0]     base_i,
  input  logic              pause_en_i,
  input  logic              pause_i,
  output logic              go_o,
  output logic [AW-1:0]     qptr_o,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [AW-1:0]     mem_addr_o,
  output logic [31:0]       mem_wdata_o,
  input  logic              mem_ack_i,
  input  logic [31:0]       mem_rdata_i,
  output logic              buf_valid_o,
  input  logic              buf_ready_i,
  output logic [31:0]       buf_addr_o,
  output logic [LEN_W-1:0]  buf_len_o,
  output logic              buf_crc_o,
  output logic              buf_last_o,
  input  logic              res_valid_i,
  input  logic              res_coll_i,
  input  logic              res_err_i,
  input  logic [STAT_W-1:0] res_stat_i
);
  logic          go, halt_pend, idle, clr_go, halt_ack;
  logic [AW-1:0] base;

  tx_bdq_ctrl #(.AW(AW)) u_ctrl (
    .clk_i, .rst_ni,
    .en_i       (tx_en_i),
    .start_i, .halt_i, .base_we_i, .base_i,
    .idle_i     (idle),
    .clr_go_i   (clr_go),
    .halt_ack_i (halt_ack),
    .go_o       (go),
    .halt_pend_o(halt_pend),
    .base_o     (base)
  );

  tx_bdq_walker #(.AW(AW)) u_walk (
    .clk_i, .rst_ni,
    .en_i       (tx_en_i),
    .go_i       (go),
    .halt_pend_i(halt_pend),
    .pause_en_i, .pause_i,
    .base_i     (base),
    .qptr_o, 
    .idle_o     (idle),
    .clr_go_o   (clr_go),
    .halt_ack_o (halt_ack),
    .mem_req_o, .mem_we_o, .mem_addr_o, .mem_wdata_o, .mem_ack_i, .mem_rdata_i,
    .buf_valid_o, .buf_ready_i, .buf_addr_o, .buf_len_o, .buf_crc_o, .buf_last_o,
    .res_valid_i, .res_coll_i, .res_err_i, .res_stat_i
  );

  assign go_o = go;
endmodule

// File: tb/tx_bdq_tb.sv
module tx_bdq_tb;
  localparam int AW = 32;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic tx_en = 0, start = 0, halt = 0, base_we = 0, pause_en = 0, pause = 0;
  logic [AW-1:0] base_d = '0;
  logic go;
  logic [AW-1:0] qptr, mem_addr;
  logic mem_req, mem_we, mem_ack = 0;
  logic [31:0] mem_wdata, mem_rdata = '0;
  logic buf_valid, buf_ready = 0, buf_crc, buf_last;
  logic [31:0] buf_addr;
  logic [13:0] buf_len;
  logic res_valid = 0, res_coll = 0, res_err = 0;
  logic [9:0] res_stat = '0;

  always #2 clk = ~clk;

  tx_bdq #(.AW(AW)) u_dut (
    .clk_i(clk), .rst_ni, .tx_en_i(tx_en), .start_i(start), .halt_i(halt),
    .base_we_i(base_we), .base_i(base_d), .pause_en_i(pause_en), .pause_i(pause),
    .go_o(go), .qptr_o(qptr), .mem_req_o(mem_req), .mem_we_o(mem_we),
    .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata), .mem_ack_i(mem_ack),
    .mem_rdata_i(mem_rdata), .buf_valid_o(buf_valid), .buf_ready_i(buf_ready),
    .buf_addr_o(buf_addr), .buf_len_o(buf_len), .buf_crc_o(buf_crc),
    .buf_last_o(buf_last), .res_valid_i(res_valid), .res_coll_i(res_coll),
    .res_err_i(res_err), .res_stat_i(res_stat)
  );

  // descriptor memory: 64 words from 0x100
  logic [31:0] mem [64];
  int rd_n, wb_n;
  logic [31:0] rd_log [8];
  // engine model
  logic [31:0] lg_addr [16];
  logic [13:0] lg_len [16];
  logic lg_last [16], lg_crc [16];
  int lg_n, coll_left;
  logic pend_res, eng_hold, err_mode;
  logic [9:0] stat_val;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always @(negedge clk) begin
    if (mem_ack) mem_ack = 1'b0;
    else if (mem_req) begin
      mem_ack = 1'b1;
      if (mem_we) begin mem[mem_addr[7:2]] = mem_wdata; wb_n++; end
      else begin
        mem_rdata = mem[mem_addr[7:2]];
        if (rd_n < 8) rd_log[rd_n] = mem_addr;
        rd_n++;
      end
    end
    if (res_valid) res_valid = 1'b0;
    else if (pend_res && !eng_hold) begin
      res_valid = 1'b1;
      res_coll  = (coll_left > 0);
      if (coll_left > 0) coll_left--;
      res_err   = err_mode && !res_coll;
      res_stat  = stat_val;
      pend_res  = 1'b0;
    end
    if (buf_ready) buf_ready = 1'b0;
    else if (buf_valid) begin
      buf_ready = 1'b1;
      if (lg_n < 16) begin
        lg_addr[lg_n] = buf_addr; lg_len[lg_n] = buf_len;
        lg_last[lg_n] = buf_last; lg_crc[lg_n] = buf_crc;
      end
      lg_n++;
      if (buf_last) pend_res = 1'b1;
    end
  end

  // ring table: buffer address, control word, expected len/last/crc
  localparam logic [79:0] RING [3] = '{
    {32'h2000_0000, 32'h0001_8040, 14'd64,  1'b1, 1'b1},
    {32'h2000_1000, 32'h0001_0064, 14'd100, 1'b0, 1'b1},
    {32'h2000_2000, 32'h4000_801C, 14'd28,  1'b1, 1'b0}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic init_env();
    for (int i = 0; i < 64; i++) mem[i] = 32'h0;
    rd_n = 0; wb_n = 0; lg_n = 0; coll_left = 0;
    pend_res = 0; eng_hold = 0; err_mode = 0; stat_val = 10'h0;
  endtask

  task automatic put_desc(input int slot, input logic [31:0] a, input logic [31:0] c);
    mem[slot*4] = a; mem[slot*4+1] = c;
  endtask

  task automatic pulse_start(); start = 1; @(negedge clk); start = 0; endtask
  task automatic pulse_halt();  halt  = 1; @(negedge clk); halt  = 0; endtask
  task automatic write_base(input logic [31:0] b);
    base_d = b; base_we = 1; @(negedge clk); base_we = 0;
  endtask

  task automatic ring_reset();
    tx_en = 0; @(negedge clk); @(negedge clk); tx_en = 1; @(negedge clk);
  endtask

  task automatic wait_idle_go();
    for (int i = 0; i < 600; i++) begin
      if (!go) break;
      @(negedge clk);
    end
    repeat (6) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(4 * 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    init_env();
    @(negedge clk);
    // reset state
    chk("R7 reset go", {31'b0, go}, 32'h0);
    chk("R13 reset req", {31'b0, mem_req}, 32'h0);
    chk("R1 reset valid", {31'b0, buf_valid}, 32'h0);
    chk("R6 reset ptr", qptr, 32'h0);
    rst_ni = 1; @(negedge clk);

    // S1: table-driven ring with wrap, ends on software-owned descriptor
    init_env();
    for (int i = 0; i < 3; i++) put_desc(i, RING[i][79:48], RING[i][47:16]);
    stat_val = 10'h008;
    write_base(32'h100); @(negedge clk);
    chk("R6 disabled ptr follows base", qptr, 32'h100);
    tx_en = 1; @(negedge clk);
    pulse_start();
    chk("R7 go set", {31'b0, go}, 32'h1);
    wait_idle_go();
    chk("R1 buffer count", lg_n, 3);
    for (int i = 0; i < 3; i++) begin
      chk("R1 buf addr", lg_addr[i], RING[i][79:48]);
      chk("R1 buf len", {18'b0, lg_len[i]}, {18'b0, RING[i][15:2]});
      chk("R1 buf last", {31'b0, lg_last[i]}, {31'b0, RING[i][1]});
      chk("R1 buf crc", {31'b0, lg_crc[i]}, {31'b0, RING[i][0]});
    end
    chk("R13 first read word0", rd_log[0], 32'h100);
    chk("R13 first read word1", rd_log[1], 32'h104);
    chk("R4 advance by 16", rd_log[2], 32'h110);
    chk("R3 status frame0", mem[1], 32'h8080_0000);
    chk("R3 status frame1 first", mem[5], 32'h8080_0000);
    chk("R3 non-first untouched", mem[9], 32'h4000_801C);
    chk("R3 write count", wb_n, 2);
    chk("R4 wrap to base then R2 stop", qptr, 32'h100);
    chk("R2 go cleared on used", {31'b0, go}, 32'h0);

    // S2: halt deferral, repeat start, base write locked
    init_env();
    ring_reset();
    put_desc(0, 32'h3000_0000, 32'h0000_8010);
    put_desc(1, 32'h3000_1000, 32'h0000_8020);
    mem[9] = 32'h8000_0000;
    eng_hold = 1; stat_val = 10'h001;
    pulse_start();
    for (int i = 0; i < 100; i++) begin if (pend_res) break; @(negedge clk); end
    pulse_start();
    write_base(32'h180);
    pulse_halt();
    repeat (5) @(negedge clk);
    chk("R9 go held during frame", {31'b0, go}, 32'h1);
    chk("R7 repeated start harmless", lg_n, 1);
    eng_hold = 0;
    wait_idle_go();
    chk("R9 halt after frame", lg_n, 1);
    chk("R9 status written before halt", mem[1], 32'h8010_0000);
    chk("R8 halt clears go", {31'b0, go}, 32'h0);
    chk("R6 halt keeps ptr", qptr, 32'h110);
    tx_en = 0; @(negedge clk); @(negedge clk);
    chk("R5 write while active ignored", qptr, 32'h100);
    write_base(32'h140); @(negedge clk);
    chk("R5 write while disabled taken", qptr, 32'h140);
    write_base(32'h100); @(negedge clk);

    // S3: pause holds fetch; disable clears go
    init_env();
    put_desc(0, 32'h4000_0000, 32'h0000_8008);
    mem[5] = 32'h8000_0000;
    tx_en = 1; @(negedge clk);
    pause_en = 1; pause = 1;
    pulse_start();
    repeat (20) @(negedge clk);
    chk("R10 no reads while paused", rd_n, 0);
    chk("R10 go kept while paused", {31'b0, go}, 32'h1);
    pause = 0;
    wait_idle_go();
    chk("R10 frame after release", lg_n, 1);
    ring_reset();
    pause = 1;
    pulse_start();
    tx_en = 0; @(negedge clk);
    chk("R8 disable clears go", {31'b0, go}, 32'h0);
    pause = 0; pause_en = 0;

    // S4: collision replays frame from first buffer
    init_env();
    put_desc(0, 32'h5000_0000, 32'h0001_0040);
    put_desc(1, 32'h5000_1000, 32'h0000_8050);
    mem[9] = 32'h8000_0000;
    coll_left = 1; stat_val = 10'h000;
    ring_reset();
    pulse_start();
    wait_idle_go();
    chk("R11 buffers incl replay", lg_n, 4);
    chk("R11 replay starts at first", lg_addr[2], 32'h5000_0000);
    chk("R11 replay second", lg_addr[3], 32'h5000_1000);
    chk("R11 single write-back", wb_n, 1);
    chk("R11 second desc untouched", mem[5], 32'h0000_8050);
    chk("R2 ptr at owned desc", qptr, 32'h120);

    // S5: error writes status, parks pointer
    init_env();
    put_desc(0, 32'h6000_0000, 32'h0000_8030);
    put_desc(1, 32'h6000_1000, 32'h0000_8030);
    err_mode = 1; stat_val = 10'h201;
    ring_reset();
    pulse_start();
    wait_idle_go();
    chk("R12 one frame only", lg_n, 1);
    chk("R12 error status", mem[1], 32'hA010_0000);
    chk("R12 ptr at failed frame", qptr, 32'h100);
    chk("R12 go cleared", {31'b0, go}, 32'h0);

    finish_run();
  end
endmodule